// File: doc/BRIEF.md
# PC-Relative and Compact Branch Unit

This unit resolves control flow and PC-relative arithmetic for a 32-bit core whose branches are all compact: no branch has a delay slot, and every link value is the address of the next instruction (PC + 4). Each cycle the pipeline may offer one decoded instruction with `in_valid`. The offer carries the current PC, the two source operand values, the rs register index, a 3-bit operation class and the immediate fields. One cycle later the unit returns the next PC, a redirect flag, an optional link write to register 31, an optional PC-relative ALU write and an optional load-address request.

The PC-relative class takes its sub-operation from nested fields of the 21-bit immediate. Bits 20:16 are tested first for the two upper-immediate forms. If neither matches, bits 20:19 pick between the add-immediate form and the load-address form. Any other pattern is flagged as illegal. An illegal instruction, whether from an unknown sub-operation or an unknown class, raises `illegal` and suppresses every write and redirect. The register file and memory are outside the unit.

Internally a two-state controller (ST_IDLE, ST_RESULT) holds the registered result. ST_IDLE moves to ST_RESULT when `in_valid` is sampled high. ST_RESULT stays in ST_RESULT while `in_valid` is high and returns to ST_IDLE when it is low.

Top module: `pcrel_branch_unit`

## Requirements
- R1: After reset every output is zero. A result appears on the outputs in the cycle after `in_valid` is sampled high, with `out_valid` high for that one cycle. When `in_valid` is sampled low, all write, request, redirect and illegal strobes are low in the following cycle. Class 0 (sequential) gives next_pc = PC + 4 with no strobes.
- R2: Class 1 (compact branch) gives next_pc = PC + 4 + (imm26 sign-extended from bit 25, shifted left 2), with `pc_redirect` high and no link write.
- R3: Class 2 (compact branch and link) uses the same target as R2 and writes PC + 4 to register 31 (`link_we` high, `link_idx` = 31).
- R4: Class 3 with a nonzero rs index is branch-if-zero. When the rs value is 0, next_pc = PC + 4 + (imm21 sign-extended from bit 20, shifted left 2) with `pc_redirect` high. Otherwise next_pc = PC + 4 and `pc_redirect` is low.
- R5: Class 3 with rs index 0 is jump indexed: next_pc = rt + (imm16 sign-extended), with `pc_redirect` high and no link write.
- R6: Class 4 (jump indexed, link form) gives next_pc = rt + (imm16 sign-extended) with `pc_redirect` high. It writes PC + 4 to register 31 only when `link_sel` is 1.
- R7: Class 5 with imm21[20:16] = 5'b11110 writes PC + (imm16 << 16) to the register named by the rs index. With 5'b11111 it writes the same sum with its low 16 bits cleared.
- R8: Class 5 otherwise decodes imm21[20:19]. 2'b00 writes PC + (imm19 sign-extended from bit 18, shifted left 2) to the rs-index register. 2'b01 raises `ld_req` with that same address on `ld_addr` and makes no ALU write. No class-5 form redirects, and each gives next_pc = PC + 4.
- R9: Class 5 with imm21[20:19] = 2'b10, or 2'b11 other than the two codes of R7, and classes 6 and 7, raise `illegal`. For these `pc_redirect`, `link_we`, `alu_we` and `ld_req` are low and next_pc = PC + 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | An instruction is offered this cycle |
| opcode | input | 3 | Operation class (0 to 7) |
| link_sel | input | 1 | Chooses the linking form of class 4 |
| pc | input | 32 | Address of the current instruction |
| rs_val | input | 32 | Value of the rs operand |
| rt_val | input | 32 | Value of the rt operand |
| rs_idx | input | 5 | Index of the rs register |
| imm16 | input | 16 | 16-bit immediate |
| imm19 | input | 19 | 19-bit immediate |
| imm21 | input | 21 | 21-bit immediate |
| imm26 | input | 26 | 26-bit immediate |
| out_valid | output | 1 | Result of the previous offer is present |
| next_pc | output | 32 | Address of the next instruction |
| pc_redirect | output | 1 | Fetch must go to next_pc |
| link_we | output | 1 | Link write request |
| link_idx | output | 5 | Link destination register (31) |
| link_data | output | 32 | Link value, PC + 4 |
| alu_we | output | 1 | PC-relative result write request |
| alu_idx | output | 5 | PC-relative result destination |
| alu_data | output | 32 | PC-relative result |
| ld_req | output | 1 | PC-relative load request |
| ld_addr | output | 32 | Load word address |
| illegal | output | 1 | Instruction not recognised |

## Verification
A wrong controller state shows up as `out_valid` or a strobe held for a second cycle, or missing in the cycle right after an offer. It is therefore visible at the ports one cycle after the faulty edge. A fault in the nested sub-operation decode shows as the wrong one of `alu_we`, `ld_req` and `illegal` in the result cycle. A fault in sign extension or shifting shows only when an offset is negative, or when its top bit falls on the carry boundary. The directed cases therefore drive negative imm26, imm21, imm16 and imm19 values, and carries out of the low half for the upper-immediate forms.

// File: rtl/pcb_pkg.sv
package pcb_pkg;

    typedef enum logic [2:0] {
        OPC_SEQ   = 3'd0,
        OPC_BRA   = 3'd1,
        OPC_BRAL  = 3'd2,
        OPC_ZJ    = 3'd3,
        OPC_JXL   = 3'd4,
        OPC_PCREL = 3'd5
    } opc_e;

    typedef enum logic {
        ST_IDLE   = 1'b0,
        ST_RESULT = 1'b1
    } ctl_state_e;

    // Sub-operation codes of the PC-relative class
    localparam logic [4:0] SUB_ADDUP    = 5'b11110;
    localparam logic [4:0] SUB_ADDUP_AL = 5'b11111;
    localparam logic [1:0] SUB_ADDI     = 2'b00;
    localparam logic [1:0] SUB_LOADW    = 2'b01;

endpackage

// File: rtl/pcb_branch.sv
module pcb_branch
    import pcb_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int REGW = 5
) (
    input  logic [2:0]      opcode,
    input  logic            link_sel,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic [REGW-1:0] rs_idx,
    input  logic [15:0]     imm16,
    input  logic [20:0]     imm21,
    input  logic [25:0]     imm26,
    output logic            br_redirect,
    output logic [XLEN-1:0] br_target,
    output logic            br_link
);

    logic [XLEN-1:0] pc_seq;
    logic [XLEN-1:0] off_long;
    logic [XLEN-1:0] off_zero;
    logic [XLEN-1:0] off_idx;

    assign pc_seq   = pc + XLEN'(4);
    assign off_long = XLEN'($signed(imm26)) << 2;
    assign off_zero = XLEN'($signed(imm21)) << 2;
    assign off_idx  = XLEN'($signed(imm16));

    always_comb begin
        br_redirect = 1'b0;
        br_target   = pc_seq;
        br_link     = 1'b0;
        unique case (opcode)
            OPC_BRA: begin
                br_redirect = 1'b1;
                br_target   = pc_seq + off_long;
            end
            OPC_BRAL: begin
                br_redirect = 1'b1;
                br_target   = pc_seq + off_long;
                br_link     = 1'b1;
            end
            OPC_ZJ: begin
                if (rs_idx != '0) begin
                    if (rs_val == '0) begin
                        br_redirect = 1'b1;
                        br_target   = pc_seq + off_zero;
                    end
                end else begin
                    br_redirect = 1'b1;
                    br_target   = rt_val + off_idx;
                end
            end
            OPC_JXL: begin
                br_redirect = 1'b1;
                br_target   = rt_val + off_idx;
                br_link     = link_sel;
            end
            default: begin
                br_redirect = 1'b0;
                br_target   = pc_seq;
                br_link     = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pcb_pcrel.sv
module pcb_pcrel
    import pcb_pkg::*;
#(
    parameter int XLEN = 32
) (
    input  logic [XLEN-1:0] pc,
    input  logic [15:0]     imm16,
    input  logic [18:0]     imm19,
    input  logic [4:0]      sel,
    output logic            pr_alu,
    output logic [XLEN-1:0] pr_data,
    output logic            pr_load,
    output logic [XLEN-1:0] pr_addr,
    output logic            pr_bad
);

    localparam int LOWW = 16;

    logic [XLEN-1:0] upper_sum;
    logic [XLEN-1:0] word_sum;

    assign upper_sum = pc + (XLEN'($signed(imm16)) << LOWW);
    assign word_sum  = pc + (XLEN'($signed(imm19)) << 2);
    assign pr_addr   = word_sum;

    always_comb begin
        pr_alu  = 1'b0;
        pr_data = '0;
        pr_load = 1'b0;
        pr_bad  = 1'b0;
        if (sel == SUB_ADDUP) begin
            pr_alu  = 1'b1;
            pr_data = upper_sum;
        end else if (sel == SUB_ADDUP_AL) begin
            pr_alu  = 1'b1;
            pr_data = {upper_sum[XLEN-1:LOWW], {LOWW{1'b0}}};
        end else begin
            unique case (sel[4:3])
                SUB_ADDI: begin
                    pr_alu  = 1'b1;
                    pr_data = word_sum;
                end
                SUB_LOADW: pr_load = 1'b1;
                default:   pr_bad  = 1'b1;
            endcase
        end
    end

endmodule

// File: rtl/pcb_ctl.sv
module pcb_ctl
    import pcb_pkg::*;
#(
    parameter int XLEN = 32,
    parameter int REGW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [XLEN-1:0] d_next_pc,
    input  logic            d_redirect,
    input  logic            d_link_we,
    input  logic [XLEN-1:0] d_link_data,
    input  logic            d_alu_we,
    input  logic [REGW-1:0] d_alu_idx,
    input  logic [XLEN-1:0] d_alu_data,
    input  logic            d_ld_req,
    input  logic [XLEN-1:0] d_ld_addr,
    input  logic            d_illegal,
    output logic            out_valid,
    output logic [XLEN-1:0] next_pc,
    output logic            pc_redirect,
    output logic            link_we,
    output logic [XLEN-1:0] link_data,
    output logic            alu_we,
    output logic [REGW-1:0] alu_idx,
    output logic [XLEN-1:0] alu_data,
    output logic            ld_req,
    output logic [XLEN-1:0] ld_addr,
    output logic            illegal
);

    ctl_state_e state;
    ctl_state_e state_nx;

    always_comb begin
        unique case (state)
            ST_IDLE:   state_nx = in_valid ? ST_RESULT : ST_IDLE;
            ST_RESULT: state_nx = in_valid ? ST_RESULT : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    assign out_valid = (state == ST_RESULT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            next_pc     <= '0;
            pc_redirect <= 1'b0;
            link_we     <= 1'b0;
            link_data   <= '0;
            alu_we      <= 1'b0;
            alu_idx     <= '0;
            alu_data    <= '0;
            ld_req      <= 1'b0;
            ld_addr     <= '0;
            illegal     <= 1'b0;
        end else if (state_nx == ST_RESULT) begin
            next_pc     <= d_next_pc;
            pc_redirect <= d_redirect;
            link_we     <= d_link_we;
            link_data   <= d_link_data;
            alu_we      <= d_alu_we;
            alu_idx     <= d_alu_idx;
            alu_data    <= d_alu_data;
            ld_req      <= d_ld_req;
            ld_addr     <= d_ld_addr;
            illegal     <= d_illegal;
        end else begin
            pc_redirect <= 1'b0;
            link_we     <= 1'b0;
            alu_we      <= 1'b0;
            ld_req      <= 1'b0;
            illegal     <= 1'b0;
        end
    end

endmodule

// File: rtl/pcrel_branch_unit.sv
module pcrel_branch_unit
    import pcb_pkg::*;
#(
    parameter int XLEN     = 32,
    parameter int REGW     = 5,
    parameter int LINK_REG = 31
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [2:0]      opcode,
    input  logic            link_sel,
    input  logic [XLEN-1:0] pc,
    input  logic [XLEN-1:0] rs_val,
    input  logic [XLEN-1:0] rt_val,
    input  logic [REGW-1:0] rs_idx,
    input  logic [15:0]     imm16,
    input  logic [18:0]     imm19,
    input  logic [20:0]     imm21,
    input  logic [25:0]     imm26,
    output logic            out_valid,
    output logic [XLEN-1:0] next_pc,
    output logic            pc_redirect,
    output logic            link_we,
    output logic [REGW-1:0] link_idx,
    output logic [XLEN-1:0] link_data,
    output logic            alu_we,
    output logic [REGW-1:0] alu_idx,
    output logic [XLEN-1:0] alu_data,
    output logic            ld_req,
    output logic [XLEN-1:0] ld_addr,
    output logic            illegal
);

    logic            br_redirect;
    logic [XLEN-1:0] br_target;
    logic            br_link;
    logic            pr_alu;
    logic [XLEN-1:0] pr_data;
    logic            pr_load;
    logic [XLEN-1:0] pr_addr;
    logic            pr_bad;

    logic            is_pcrel;
    logic            bad_class;
    logic            bad_any;
    logic [XLEN-1:0] pc_seq;

    pcb_branch #(.XLEN(XLEN), .REGW(REGW)) u_branch (
        .opcode      (opcode),
        .link_sel    (link_sel),
        .pc          (pc),
        .rs_val      (rs_val),
        .rt_val      (rt_val),
        .rs_idx      (rs_idx),
        .imm16       (imm16),
        .imm21       (imm21),
        .imm26       (imm26),
        .br_redirect (br_redirect),
        .br_target   (br_target),
        .br_link     (br_link)
    );

    pcb_pcrel #(.XLEN(XLEN)) u_pcrel (
        .pc      (pc),
        .imm16   (imm16),
        .imm19   (imm19),
        .sel     (imm21[20:16]),
        .pr_alu  (pr_alu),
        .pr_data (pr_data),
        .pr_load (pr_load),
        .pr_addr (pr_addr),
        .pr_bad  (pr_bad)
    );

    assign pc_seq    = pc + XLEN'(4);
    assign is_pcrel  = (opcode == OPC_PCREL);
    assign bad_class = (opcode > OPC_PCREL);
    assign bad_any   = bad_class | (is_pcrel & pr_bad);
    assign link_idx  = REGW'(LINK_REG);

    pcb_ctl #(.XLEN(XLEN), .REGW(REGW)) u_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .d_next_pc   (bad_any ? pc_seq : br_target),
        .d_redirect  (br_redirect & ~bad_any),
        .d_link_we   (br_link & ~bad_any),
        .d_link_data (pc_seq),
        .d_alu_we    (is_pcrel & pr_alu & ~bad_any),
        .d_alu_idx   (rs_idx),
        .d_alu_data  (pr_data),
        .d_ld_req    (is_pcrel & pr_load & ~bad_any),
        .d_ld_addr   (pr_addr),
        .d_illegal   (bad_any),
        .out_valid   (out_valid),
        .next_pc     (next_pc),
        .pc_redirect (pc_redirect),
        .link_we     (link_we),
        .link_data   (link_data),
        .alu_we      (alu_we),
        .alu_idx     (alu_idx),
        .alu_data    (alu_data),
        .ld_req      (ld_req),
        .ld_addr     (ld_addr),
        .illegal     (illegal)
    );

endmodule

// File: rtl/pcrel_branch_unit_chk.sv
module pcrel_branch_unit_chk #(
    parameter int XLEN = 32,
    parameter int REGW = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            in_valid,
    input logic [XLEN-1:0] pc,
    input logic            out_valid,
    input logic [XLEN-1:0] next_pc,
    input logic            pc_redirect,
    input logic            link_we,
    input logic [REGW-1:0] link_idx,
    input logic [XLEN-1:0] link_data,
    input logic            alu_we,
    input logic            ld_req,
    input logic            illegal
);

    AST_RESULT_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid); // R1

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !(pc_redirect || link_we || alu_we || ld_req || illegal)); // R1

    AST_LINK_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        link_we |-> link_idx == REGW'(31)); // R3

    AST_LINK_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && link_we) |-> link_data == $past(pc) + XLEN'(4)); // R6

    AST_FALLTHROUGH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !pc_redirect) |-> next_pc == $past(pc) + XLEN'(4)); // R4

    AST_ILLEGAL_MUTE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> !(pc_redirect || link_we || alu_we || ld_req)); // R9

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({alu_we, ld_req, illegal})); // R8

endmodule

bind pcrel_branch_unit pcrel_branch_unit_chk #(.XLEN(XLEN), .REGW(REGW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .pc          (pc),
    .out_valid   (out_valid),
    .next_pc     (next_pc),
    .pc_redirect (pc_redirect),
    .link_we     (link_we),
    .link_idx    (link_idx),
    .link_data   (link_data),
    .alu_we      (alu_we),
    .ld_req      (ld_req),
    .illegal     (illegal)
);

// File: tb/pcrel_branch_unit_tb.sv
`timescale 1ns/1ps
module pcrel_branch_unit_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [2:0]  opcode = '0;
    logic        link_sel = 1'b0;
    logic [31:0] pc = '0, rs_val = '0, rt_val = '0;
    logic [4:0]  rs_idx = '0;
    logic [15:0] imm16 = '0;
    logic [18:0] imm19 = '0;
    logic [20:0] imm21 = '0;
    logic [25:0] imm26 = '0;
    logic        out_valid, pc_redirect, link_we, alu_we, ld_req, illegal;
    logic [31:0] next_pc, link_data, alu_data, ld_addr;
    logic [4:0]  link_idx, alu_idx;

    int checks = 0;
    int failures = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    pcrel_branch_unit u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .opcode(opcode),
        .link_sel(link_sel), .pc(pc), .rs_val(rs_val), .rt_val(rt_val),
        .rs_idx(rs_idx), .imm16(imm16), .imm19(imm19), .imm21(imm21),
        .imm26(imm26), .out_valid(out_valid), .next_pc(next_pc),
        .pc_redirect(pc_redirect), .link_we(link_we), .link_idx(link_idx),
        .link_data(link_data), .alu_we(alu_we), .alu_idx(alu_idx),
        .alu_data(alu_data), .ld_req(ld_req), .ld_addr(ld_addr),
        .illegal(illegal)
    );

    always @(posedge clk) begin
        cycles++;
        if (cycles > 5000) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<=5000", cycles);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] sx26(input logic [25:0] v);
        return {{6{v[25]}}, v};
    endfunction
    function automatic logic [31:0] sx21(input logic [20:0] v);
        return {{11{v[20]}}, v};
    endfunction
    function automatic logic [31:0] sx19(input logic [18:0] v);
        return {{13{v[18]}}, v};
    endfunction
    function automatic logic [31:0] sx16(input logic [15:0] v);
        return {{16{v[15]}}, v};
    endfunction

    // Offer one instruction; returns just after the capturing edge.
    task automatic issue(input logic [2:0] op, input logic ls,
                         input logic [31:0] p, input logic [31:0] rsv,
                         input logic [31:0] rtv, input logic [4:0] ri,
                         input logic [20:0] i21, input logic [25:0] i26);
        @(negedge clk);
        opcode = op; link_sel = ls; pc = p; rs_val = rsv; rt_val = rtv;
        rs_idx = ri; imm21 = i21; imm16 = i21[15:0]; imm19 = i21[18:0];
        imm26 = i26; in_valid = 1'b1;
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    task automatic strobes(input string req, input logic r, input logic l,
                           input logic a, input logic ld, input logic il);
        chk(req, "out_valid", 32'(out_valid), 32'd1);
        chk(req, "pc_redirect", 32'(pc_redirect), 32'(r));
        chk(req, "link_we", 32'(link_we), 32'(l));
        chk(req, "alu_we", 32'(alu_we), 32'(a));
        chk(req, "ld_req", 32'(ld_req), 32'(ld));
        chk(req, "illegal", 32'(illegal), 32'(il));
    endtask

    task automatic t_reset();
        chk("R1", "reset out_valid", 32'(out_valid), 32'd0);
        chk("R1", "reset next_pc", next_pc, 32'd0);
        chk("R1", "reset strobes", 32'({pc_redirect, link_we, alu_we, ld_req, illegal}), 32'd0);
    endtask

    task automatic t_seq_and_idle();
        issue(3'd0, 1'b0, 32'h0000_2000, 32'd0, 32'd0, 5'd1, 21'd0, 26'd0);
        strobes("R1", 0, 0, 0, 0, 0);
        chk("R1", "seq next_pc", next_pc, 32'h0000_2004);
        @(posedge clk); #1;
        chk("R1", "idle out_valid", 32'(out_valid), 32'd0);
        chk("R1", "idle strobes", 32'({pc_redirect, link_we, alu_we, ld_req, illegal}), 32'd0);
    endtask

    task automatic t_branch();
        logic [25:0] o;
        o = 26'h3FF_FFF0;
        issue(3'd1, 1'b0, 32'h0000_1000, 32'd0, 32'd0, 5'd0, 21'd0, o);
        strobes("R2", 1, 0, 0, 0, 0);
        chk("R2", "negative target", next_pc, 32'h0000_1004 + (sx26(o) << 2));
        o = 26'h000_0010;
        issue(3'd1, 1'b0, 32'h0000_1000, 32'd0, 32'd0, 5'd0, 21'd0, o);
        chk("R2", "positive target", next_pc, 32'h0000_1044);
    endtask

    task automatic t_branch_link();
        logic [25:0] o;
        o = 26'h200_0000;
        issue(3'd2, 1'b0, 32'h1000_0000, 32'd0, 32'd0, 5'd0, 21'd0, o);
        strobes("R3", 1, 1, 0, 0, 0);
        chk("R3", "target", next_pc, 32'h1000_0004 + (sx26(o) << 2));
        chk("R3", "link_idx", 32'(link_idx), 32'd31);
        chk("R3", "link_data", link_data, 32'h1000_0004);
    endtask

    task automatic t_zero_branch();
        logic [20:0] o;
        o = 21'h1F_FFFE;
        issue(3'd3, 1'b0, 32'h0000_4000, 32'd0, 32'h55, 5'd3, o, 26'd0);
        strobes("R4", 1, 0, 0, 0, 0);
        chk("R4", "taken target", next_pc, 32'h0000_4004 + (sx21(o) << 2));
        issue(3'd3, 1'b0, 32'h0000_4000, 32'd5, 32'h55, 5'd3, o, 26'd0);
        strobes("R4", 0, 0, 0, 0, 0);
        chk("R4", "not taken next_pc", next_pc, 32'h0000_4004);
    endtask

    task automatic t_jump_index();
        issue(3'd3, 1'b0, 32'h0000_4000, 32'd0, 32'h0000_2000, 5'd0, 21'h1F_8000, 26'd0);
        strobes("R5", 1, 0, 0, 0, 0);
        chk("R5", "target", next_pc, 32'h0000_2000 + sx16(16'h8000));
    endtask

    task automatic t_jump_link();
        issue(3'd4, 1'b1, 32'h0000_0800, 32'd0, 32'h0001_0000, 5'd0, 21'h00_FFFC, 26'd0);
        strobes("R6", 1, 1, 0, 0, 0);
        chk("R6", "target", next_pc, 32'h0000_FFFC);
        chk("R6", "link_data", link_data, 32'h0000_0804);
        issue(3'd4, 1'b0, 32'h0000_0800, 32'd0, 32'h0001_0000, 5'd0, 21'h00_0010, 26'd0);
        strobes("R6", 1, 0, 0, 0, 0);
        chk("R6", "no-link target", next_pc, 32'h0001_0010);
    endtask

    task automatic t_upper();
        issue(3'd5, 1'b0, 32'h0040_1234, 32'd0, 32'd0, 5'd7, {5'b11110, 16'h8001}, 26'd0);
        strobes("R7", 0, 0, 1, 0, 0);
        chk("R7", "upper sum", alu_data, 32'h0040_1234 + 32'h8001_0000);
        chk("R7", "dest", 32'(alu_idx), 32'd7);
        chk("R7", "next_pc", next_pc, 32'h0040_1238);
        issue(3'd5, 1'b0, 32'h0041_F234, 32'd0, 32'd0, 5'd9, {5'b11111, 16'h0002}, 26'd0);
        strobes("R7", 0, 0, 1, 0, 0);
        chk("R7", "aligned sum", alu_data, 32'h0043_0000);
        chk("R7", "aligned dest", 32'(alu_idx), 32'd9);
    endtask

    task automatic t_word_ops();
        logic [18:0] o;
        o = 19'h7_FFFF;
        issue(3'd5, 1'b0, 32'h0000_3000, 32'd0, 32'd0, 5'd12, {2'b00, o}, 26'd0);
        strobes("R8", 0, 0, 1, 0, 0);
        chk("R8", "add-imm result", alu_data, 32'h0000_3000 + (sx19(o) << 2));
        chk("R8", "add-imm dest", 32'(alu_idx), 32'd12);
        o = 19'h4_0001;
        issue(3'd5, 1'b0, 32'h0010_0000, 32'd0, 32'd0, 5'd12, {2'b01, o}, 26'd0);
        strobes("R8", 0, 0, 0, 1, 0);
        chk("R8", "load addr", ld_addr, 32'h0010_0000 + (sx19(o) << 2));
        chk("R8", "load next_pc", next_pc, 32'h0010_0004);
    endtask

    task automatic t_illegal();
        issue(3'd5, 1'b0, 32'h0000_5000, 32'd0, 32'd0, 5'd4, {2'b10, 19'h1}, 26'd0);
        strobes("R9", 0, 0, 0, 0, 1);
        chk("R9", "next_pc", next_pc, 32'h0000_5004);
        issue(3'd5, 1'b0, 32'h0000_5000, 32'd0, 32'd0, 5'd4, {5'b11000, 16'h1}, 26'd0);
        strobes("R9", 0, 0, 0, 0, 1);
        issue(3'd6, 1'b1, 32'h0000_5000, 32'd0, 32'd0, 5'd4, 21'd0, 26'h10);
        strobes("R9", 0, 0, 0, 0, 1);
        chk("R9", "class 6 next_pc", next_pc, 32'h0000_5004);
    endtask

    task automatic t_back_to_back();
        issue(3'd1, 1'b0, 32'h0000_0100, 32'd0, 32'd0, 5'd0, 21'd0, 26'd1);
        issue(3'd0, 1'b0, 32'h0000_0200, 32'd0, 32'd0, 5'd0, 21'd0, 26'd0);
        strobes("R1", 0, 0, 0, 0, 0);
        chk("R1", "second result next_pc", next_pc, 32'h0000_0204);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_seq_and_idle();
        t_branch();
        t_branch_link();
        t_zero_branch();
        t_jump_index();
        t_jump_link();
        t_upper();
        t_word_ops();
        t_illegal();
        t_back_to_back();
        repeat (2) @(posedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule